// File: doc/BRIEF.md
# Pin Interrupt Sensing Unit

This block watches a bank of general-purpose input pins and turns their activity into interrupt requests. Each pin has its own configuration. A pin can be sensed as a level, with either polarity, or as an edge, and it can qualify rising edges, falling edges or both. For edge-sensed pins a further bit picks one of two behaviours: the event is latched until software clears it, or it is passed through as a one-cycle pulse.

The pins are split into a lower and an upper half. Each half is reached through its own halfword registers on a simple read/write bus. Reads are combinational and writes take effect at the clock edge. The pin inputs are synchronised inside the block before any sensing is done. Per-pin status is gated by a per-pin enable, and the gated results of both halves are combined into a single cascade interrupt line for a downstream controller.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, with all pins held high, every enable, sensing-type and select register reads 0, both status registers read 0, and `irq_o` is low.
- R2: Registers sit at fixed byte offsets; the upper half of each register is 2 above the lower half. The offsets are status 0x08, enable 0x0C, type 0x10, polarity 0x14, hold 0x18, falling qualifier 0x20 and rising qualifier 0x24. Bit n of an upper-half register maps to pin n+HALF_W. Written configuration reads back unchanged.
- R3: A type bit of 0 selects level sensing. The pin's status reads 1 while the synchronised pin equals its polarity bit (1 means active high, 0 means active low).
- R4: A type bit of 1 selects edge sensing. A 0-to-1 transition counts only when the rising qualifier bit is 1, and a 1-to-0 transition counts only when the falling qualifier bit is 1. The polarity bit has no effect in this mode.
- R5: An edge-sensed pin whose hold bit is 1 keeps its status at 1 after a qualified edge until a 1 is written to that status bit. Writing 0 to a status bit leaves it unchanged.
- R6: An edge-sensed pin whose hold bit is 0 shows status 1 for exactly one cycle per qualified edge, and nothing is latched.
- R7: When a qualified edge and a write-one-to-clear reach the same held status bit in the same cycle, the bit stays 1.
- R8: `irq_o` is high exactly when some pin has both its status and its enable at 1. Status reads do not depend on the enable bits.
- R9: A pin change is visible in status two clock edges after it is applied, not one.
- R10: A read of an offset outside the register map returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 2*HALF_W | Asynchronous input pins |
| bus_we | input | 1 | Write strobe, captured at the clock edge |
| bus_addr | input | ADDR_W | Byte address of the halfword register |
| bus_wdata | input | HALF_W | Write data |
| bus_rdata | output | HALF_W | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Cascade interrupt request |

## Verification
The bench builds the block with its default parameters: 16-bit halves, which gives 32 pins, an 8-bit address and a two-stage synchroniser. With these values both halves of every register are reached, and the upper-half pin mapping is exercised on pins spread across the whole bank. The exact two-edge synchroniser latency is also observable, so the bench samples the one-cycle pass-through pulse and forces an edge to land in the same cycle as a clear.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_STAT,
      SEL_EN,
      SEL_TYPE,
      SEL_POL,
      SEL_HOLD,
      SEL_FALL,
      SEL_RISE
   } reg_sel_e;

   localparam int unsigned NUM_SEL = 8;

   // byte offset of the lower half of each register
   function automatic int unsigned base_off(int unsigned s);
      case (s)
         1:       return 32'h08;
         2:       return 32'h0C;
         3:       return 32'h10;
         4:       return 32'h14;
         5:       return 32'h18;
         6:       return 32'h20;
         7:       return 32'h24;
         default: return 32'h0;
      endcase
   endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] cur_o,
   output logic [WIDTH-1:0] prev_o
);
   localparam int unsigned DEPTH = STAGES + 1;

   logic [WIDTH-1:0] chain_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) chain_q[k] <= '0;
      end else begin
         chain_q[0] <= d_i;
         for (int k = 1; k < DEPTH; k++) chain_q[k] <= chain_q[k-1];
      end
   end

   assign cur_o  = chain_q[STAGES-1];
   assign prev_o = chain_q[STAGES];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] cur_i,
   input  logic [WIDTH-1:0] prev_i,
   input  logic [WIDTH-1:0] edge_sel_i,
   input  logic [WIDTH-1:0] pol_i,
   input  logic [WIDTH-1:0] hold_i,
   input  logic [WIDTH-1:0] fall_i,
   input  logic [WIDTH-1:0] rise_i,
   output logic [WIDTH-1:0] ev_o,
   output logic [WIDTH-1:0] thru_o,
   output logic [WIDTH-1:0] hold_mode_o
);
   logic [WIDTH-1:0] went_up, went_down, lvl_hit;

   assign went_up     = cur_i & ~prev_i;
   assign went_down   = ~cur_i & prev_i;
   assign ev_o        = edge_sel_i & ((went_up & rise_i) | (went_down & fall_i));
   assign lvl_hit     = ~edge_sel_i & ~(cur_i ^ pol_i);
   assign thru_o      = ev_o | lvl_hit;
   assign hold_mode_o = edge_sel_i & hold_i;
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
   import gpio_irq_pkg::*;
#(
   parameter int unsigned HALF_W = 16,
   parameter int unsigned ADDR_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_we,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [HALF_W-1:0]     bus_wdata,
   input  logic [2*HALF_W-1:0]   ev_i,
   input  logic [2*HALF_W-1:0]   thru_i,
   input  logic [2*HALF_W-1:0]   hold_mode_i,
   output logic [2*HALF_W-1:0]   en_q,
   output logic [2*HALF_W-1:0]   type_q,
   output logic [2*HALF_W-1:0]   pol_q,
   output logic [2*HALF_W-1:0]   hold_q,
   output logic [2*HALF_W-1:0]   fall_q,
   output logic [2*HALF_W-1:0]   rise_q,
   output logic [2*HALF_W-1:0]   lat_q,
   output logic [2*HALF_W-1:0]   stat_view,
   output logic [2*HALF_W-1:0]   clr_mask,
   output logic [HALF_W-1:0]     bus_rdata
);
   localparam int unsigned NPINS = 2 * HALF_W;

   reg_sel_e    sel;
   logic        upper;
   int unsigned base;

   always_comb begin
      sel   = SEL_NONE;
      upper = 1'b0;
      for (int s = 1; s < NUM_SEL; s++) begin
         for (int h = 0; h < 2; h++) begin
            if (bus_addr == ADDR_W'(base_off(s) + 2 * h)) begin
               sel   = reg_sel_e'(s);
               upper = 1'(h);
            end
         end
      end
   end

   assign base = upper ? HALF_W : 0;

   always_comb begin
      clr_mask = '0;
      if (bus_we && sel == SEL_STAT) clr_mask[base +: HALF_W] = bus_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         type_q <= '0;
         pol_q  <= '0;
         hold_q <= '0;
         fall_q <= '0;
         rise_q <= '0;
      end else if (bus_we) begin
         case (sel)
            SEL_EN:   en_q[base +: HALF_W]   <= bus_wdata;
            SEL_TYPE: type_q[base +: HALF_W] <= bus_wdata;
            SEL_POL:  pol_q[base +: HALF_W]  <= bus_wdata;
            SEL_HOLD: hold_q[base +: HALF_W] <= bus_wdata;
            SEL_FALL: fall_q[base +: HALF_W] <= bus_wdata;
            SEL_RISE: rise_q[base +: HALF_W] <= bus_wdata;
            default:  ;
         endcase
      end
   end

   // a fresh event takes priority over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat_q <= '0;
      else        lat_q <= hold_mode_i & (ev_i | (lat_q & ~clr_mask));
   end

   assign stat_view = (hold_mode_i & lat_q) | (~hold_mode_i & thru_i);

   always_comb begin
      case (sel)
         SEL_STAT: bus_rdata = stat_view[base +: HALF_W];
         SEL_EN:   bus_rdata = en_q[base +: HALF_W];
         SEL_TYPE: bus_rdata = type_q[base +: HALF_W];
         SEL_POL:  bus_rdata = pol_q[base +: HALF_W];
         SEL_HOLD: bus_rdata = hold_q[base +: HALF_W];
         SEL_FALL: bus_rdata = fall_q[base +: HALF_W];
         SEL_RISE: bus_rdata = rise_q[base +: HALF_W];
         default:  bus_rdata = '0;
      endcase
   end

   if (NPINS != 2 * HALF_W) begin : g_bad_npins
      $error("pin count must equal two halves");
   end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
   parameter int unsigned HALF_W      = 16,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2*HALF_W-1:0] pin_i,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [HALF_W-1:0]   bus_wdata,
   output logic [HALF_W-1:0]   bus_rdata,
   output logic                irq_o
);
   localparam int unsigned NPINS = 2 * HALF_W;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end
   if (HALF_W < 1) begin : g_bad_half
      $error("HALF_W must be positive");
   end

   logic [NPINS-1:0] pin_cur, pin_prev;
   logic [NPINS-1:0] ev, thru, hold_mode;
   logic [NPINS-1:0] en_q, type_q, pol_q, hold_q, fall_q, rise_q;
   logic [NPINS-1:0] lat_q, stat_view, clr_mask;

   gpio_irq_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (pin_i),
      .cur_o  (pin_cur),
      .prev_o (pin_prev)
   );

   gpio_irq_detect #(.WIDTH(NPINS)) u_detect (
      .cur_i       (pin_cur),
      .prev_i      (pin_prev),
      .edge_sel_i  (type_q),
      .pol_i       (pol_q),
      .hold_i      (hold_q),
      .fall_i      (fall_q),
      .rise_i      (rise_q),
      .ev_o        (ev),
      .thru_o      (thru),
      .hold_mode_o (hold_mode)
   );

   gpio_irq_regs #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_we      (bus_we),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .ev_i        (ev),
      .thru_i      (thru),
      .hold_mode_i (hold_mode),
      .en_q        (en_q),
      .type_q      (type_q),
      .pol_q       (pol_q),
      .hold_q      (hold_q),
      .fall_q      (fall_q),
      .rise_q      (rise_q),
      .lat_q       (lat_q),
      .stat_view   (stat_view),
      .clr_mask    (clr_mask),
      .bus_rdata   (bus_rdata)
   );

   assign irq_o = |(stat_view & en_q);
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
   parameter int unsigned NPINS = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_we,
   input logic [NPINS-1:0] ev,
   input logic [NPINS-1:0] hold_mode,
   input logic [NPINS-1:0] lat_q,
   input logic [NPINS-1:0] clr_mask,
   input logic [NPINS-1:0] en_q,
   input logic             irq_o
);
   // R8
   en_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |-> !irq_o);

   // R5
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> (($past(lat_q & hold_mode) & ~lat_q) == '0));

   // R7
   ev_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ev & hold_mode) != '0) |=> (($past(ev & hold_mode) & ~lat_q) == '0));

   // R5
   w1c_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask != '0) |=> ((lat_q & $past(clr_mask & ~ev)) == '0));
endmodule

bind gpio_irq_unit gpio_irq_chk #(.NPINS(2 * HALF_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .ev        (ev),
   .hold_mode (hold_mode),
   .lat_q     (lat_q),
   .clr_mask  (clr_mask),
   .en_q      (en_q),
   .irq_o     (irq_o)
);

// File: tb/tb_gpio_irq_unit.sv
module tb_gpio_irq_unit;
   localparam int CLK_PERIOD = 10;
   localparam int HW = 16;
   localparam int NP = 2 * HW;

   localparam logic [7:0] A_STAT = 8'h08, A_EN = 8'h0C, A_TYPE = 8'h10, A_POL = 8'h14,
                          A_HOLD = 8'h18, A_FALL = 8'h20, A_RISE = 8'h24;

   // {type, pol, hold, fall, rise, start, final, expected status}
   localparam logic [7:0] VEC [13] = '{
      8'b0_0_0_0_0_1_0_1, 8'b0_0_0_0_0_0_1_0, 8'b0_1_0_0_0_0_1_1,
      8'b0_1_0_0_0_1_0_0, 8'b1_0_1_0_1_0_1_1, 8'b1_0_1_0_1_1_0_0,
      8'b1_0_1_1_0_1_0_1, 8'b1_0_1_1_0_0_1_0, 8'b1_0_1_1_1_0_1_1,
      8'b1_0_1_1_1_1_0_1, 8'b1_0_1_0_0_0_1_0, 8'b1_0_0_1_1_0_1_0,
      8'b1_1_1_1_0_1_0_1 };

   logic          clk = 0;
   logic          rst_n = 0;
   logic [NP-1:0] pins = '1;
   logic          we = 0;
   logic [7:0]    addr = 8'h00;
   logic [HW-1:0] wdata = '0;
   logic [HW-1:0] rdata;
   logic          irq;
   int            checks = 0, errors = 0;
   bit            done = 0;

   gpio_irq_unit dut (
      .clk(clk), .rst_n(rst_n), .pin_i(pins), .bus_we(we), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [HW-1:0] d);
      @(negedge clk); we = 1; addr = a; wdata = d;
      @(negedge clk); we = 0;
   endtask

   task automatic rd(logic [7:0] a, output logic [HW-1:0] d);
      @(negedge clk); addr = a; #1; d = rdata;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic cfg_pin(int p, logic t, logic pl, logic h, logic f, logic r);
      logic [7:0] off = (p >= HW) ? 8'h02 : 8'h00;
      logic [HW-1:0] m = HW'(1) << (p % HW);
      wr(A_TYPE, '0); wr(A_TYPE + 8'h02, '0);
      wr(A_POL,  '0); wr(A_POL  + 8'h02, '0);
      wr(A_HOLD, '0); wr(A_HOLD + 8'h02, '0);
      wr(A_FALL, '0); wr(A_FALL + 8'h02, '0);
      wr(A_RISE, '0); wr(A_RISE + 8'h02, '0);
      wr(A_TYPE + off, t ? m : '0);
      wr(A_POL  + off, pl ? m : '0);
      wr(A_HOLD + off, h ? m : '0);
      wr(A_FALL + off, f ? m : '0);
      wr(A_RISE + off, r ? m : '0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      logic [HW-1:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1;
      repeat (4) @(negedge clk);

      // R1 reset state
      rd(A_STAT, d);        check("R1 stat lo", d, 0);
      rd(A_STAT + 2, d);    check("R1 stat hi", d, 0);
      rd(A_EN, d);          check("R1 en lo", d, 0);
      rd(A_EN + 2, d);      check("R1 en hi", d, 0);
      rd(A_TYPE + 2, d);    check("R1 type hi", d, 0);
      check("R1 irq", irq, 0);

      // R2 readback, R10 unmapped
      wr(A_RISE, 16'hA5C3); rd(A_RISE, d); check("R2 rise lo readback", d, 16'hA5C3);
      wr(A_HOLD + 2, 16'h0F0F); rd(A_HOLD + 2, d); check("R2 hold hi readback", d, 16'h0F0F);
      rd(A_HOLD, d); check("R2 hold lo untouched", d, 0);
      rd(8'h04, d); check("R10 unmapped read", d, 0);
      rd(8'h1C, d); check("R10 gap read", d, 0);
      wr(A_RISE, '0); wr(A_HOLD + 2, '0);

      // R3 R4 R5 R6 vector table
      for (int i = 0; i < 13; i++) begin
         int p = (i * 7) % NP;
         logic [7:0] v = VEC[i];
         @(negedge clk); pins = '1; pins[p] = v[2];
         repeat (4) @(negedge clk);
         cfg_pin(p, v[7], v[6], v[5], v[4], v[3]);
         wr(A_STAT, '1); wr(A_STAT + 2, '1);
         @(negedge clk); pins[p] = v[1];
         repeat (4) @(negedge clk);
         rd(A_STAT + ((p >= HW) ? 8'h02 : 8'h00), d);
         check($sformatf("R3/R4/R5/R6 vector %0d pin %0d", i, p), 32'(d[p % HW]), 32'(v[0]));
      end

      // R5 write 0 keeps, write 1 clears (pin 8 is vector 4's? use fresh pin 5)
      @(negedge clk); pins = '1; pins[5] = 0;
      repeat (4) @(negedge clk);
      cfg_pin(5, 1, 0, 1, 0, 1);
      wr(A_STAT, '1);
      @(negedge clk); pins[5] = 1;
      repeat (4) @(negedge clk);
      wr(A_STAT, 16'h0000); rd(A_STAT, d); check("R5 write 0 keeps", 32'(d[5]), 1);
      wr(A_STAT, 16'h0020); rd(A_STAT, d); check("R5 write 1 clears", 32'(d[5]), 0);

      // R7 event and clear in same cycle
      @(negedge clk); pins[5] = 0;
      repeat (4) @(negedge clk);
      wr(A_STAT, '1);
      @(negedge clk); pins[5] = 1;
      @(posedge clk); @(posedge clk);
      @(negedge clk); we = 1; addr = A_STAT; wdata = 16'h0020;
      @(negedge clk); we = 0;
      rd(A_STAT, d); check("R7 event wins over clear", 32'(d[5]), 1);
      wr(A_STAT, 16'h0020); rd(A_STAT, d); check("R7 later clear works", 32'(d[5]), 0);

      // R6 through pulse, R9 latency, R8 irq with pulse
      @(negedge clk); pins[5] = 0;
      cfg_pin(5, 1, 0, 0, 0, 1);
      wr(A_EN, 16'h0020);
      repeat (4) @(negedge clk);
      addr = A_STAT;
      @(negedge clk); pins[5] = 1;
      @(posedge clk); #2; check("R9 not after one edge", 32'(rdata[5]), 0);
      @(posedge clk); #2; check("R6 pulse present", 32'(rdata[5]), 1);
      check("R8 irq on pulse", irq, 1);
      @(posedge clk); #2; check("R6 pulse one cycle", 32'(rdata[5]), 0);
      check("R8 irq drops", irq, 0);
      wr(A_EN, '0);

      // R9 level latency, active high pin 9
      @(negedge clk); pins = '1; pins[9] = 0;
      cfg_pin(9, 0, 1, 0, 0, 0);
      repeat (4) @(negedge clk);
      addr = A_STAT;
      @(negedge clk); pins[9] = 1;
      @(posedge clk); #2; check("R9 level after one edge", 32'(rdata[9]), 0);
      @(posedge clk); #2; check("R9 level after two edges", 32'(rdata[9]), 1);

      // R8 cascade and enable gating, pin 20 level active low
      cfg_pin(20, 0, 0, 0, 0, 0);
      @(negedge clk); pins = '1; pins[20] = 0;
      repeat (4) @(negedge clk);
      rd(A_STAT + 2, d); check("R8 status without enable", 32'(d[4]), 1);
      check("R8 irq masked", irq, 0);
      wr(A_EN, 16'h0010); check("R8 wrong half enable", irq, 0);
      wr(A_EN, 16'h0000);
      wr(A_EN + 2, 16'h0010); check("R8 irq enabled", irq, 1);
      @(negedge clk); pins[20] = 1;
      repeat (3) @(negedge clk); check("R8 irq follows status", irq, 0);

      summary();
   end
endmodule